// File: doc/BRIEF.md
# Predicated Branch Call/Return State Unit

This block resolves one branch per valid input. The branch is a conditional jump, a procedure call or a procedure return, and a one-bit qualifying predicate gates it. The unit takes the architectural control state that goes with such branches and returns the next value of each part. That state is the register-frame descriptor, the loop epilog counter, the current privilege level and the saved-state register. For a taken call, the unit also returns the return link write for a branch register. It raises a flag when a return moves to a less privileged level while the trap enable is set.

The pipeline that holds the state registers is the user of this block. It presents the current values with `in_valid` and writes back the results when `out_valid` pulses one cycle later. Target computation, fetch redirection and the register-stack spill and fill traffic belong to other blocks.

Frame descriptor layout (38 bits, LSB first):
- size in [6:0]
- locals in [13:7]
- rotating size in [17:14]
- general rename base in [24:18]
- float rename base in [31:25]
- predicate rename base in [37:32]

Saved-state layout (46 bits):
- frame in [37:0]
- epilog count in [43:38]
- privilege in [45:44]

Privilege 0 is the most privileged level. A larger number is a less privileged level.

Top module: `pred_branch_unit`

## Requirements
- R1: Every input accepted with `in_valid`=1 produces exactly one result with `out_valid`=1 on the next clock edge. `out_valid` is 0 in any cycle that follows a cycle without `in_valid`, and it is 0 during reset.
- R2: Branch kind codes are 0 conditional, 1 call, 2 return and 3 no-op. For kinds 0, 1 and 2, `out_taken` equals the predicate. Kind 3 is never taken.
- R3: A branch that is not taken returns the frame, epilog count, privilege and saved-state inputs unchanged, with no link write and no trap.
- R4: A taken conditional branch returns all state inputs unchanged, with no link write and no trap.
- R5: A taken call sets the saved-state output to {privilege, epilog count, frame}, packed as in the layout above.
- R6: On a taken call, the new frame size is the old size minus the old locals, clamped at 0 when the locals exceed the size. The new locals and rotating size are both 0. The epilog count and privilege are unchanged.
- R7: On a taken call, all three rename base fields of the frame output are 0.
- R8: A taken call asserts `out_link_we`. It echoes the selected branch register index on `out_link_sel` and drives `out_link_data` with the bundle address plus 16. No other branch writes the link.
- R9: A taken return sets the frame and epilog count outputs from the saved-state input. The saved-state output is left equal to its input.
- R10: On a taken return, the privilege output is the numerically larger of the current level and the saved level, so privilege never rises.
- R11: `out_trap` is 1 exactly when a taken return carries a saved level numerically larger than the current level and `in_lp_trap_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Branch present this cycle |
| in_kind | input | 2 | Branch kind code |
| in_pred | input | 1 | Qualifying predicate value |
| in_link_sel | input | 3 | Branch register index for the return link |
| in_frame | input | 38 | Current frame descriptor |
| in_ec | input | 6 | Current epilog count |
| in_priv | input | 2 | Current privilege level |
| in_saved | input | 46 | Current saved-state register |
| in_lp_trap_en | input | 1 | Enable for the privilege-drop trap |
| in_bundle_addr | input | 64 | Address of the branch bundle |
| out_valid | output | 1 | Result strobe |
| out_taken | output | 1 | Branch taken |
| out_frame | output | 38 | Next frame descriptor |
| out_ec | output | 6 | Next epilog count |
| out_priv | output | 2 | Next privilege level |
| out_saved | output | 46 | Next saved-state register |
| out_link_we | output | 1 | Link register write enable |
| out_link_sel | output | 3 | Link register index |
| out_link_data | output | 64 | Link value |
| out_trap | output | 1 | Privilege-drop trap flag |

## Verification
All results pass through one register stage, so a wrong decode or packing error shows on the ports in the cycle after the input. Nothing carries over from one branch to the next, and each result can be compared with a value computed from that branch's inputs alone. A swapped field in the saved-state packing shows up as soon as a call result differs from the bench model. An inverted privilege comparison shows up on the first return that tries to raise privilege. The bench puts corner inputs in back-to-back branches: locals larger than size, equal privilege levels, trap enable cleared, and the no-op code. This way a stale or misrouted field is caught in the cycle it appears.

// File: rtl/pbu_pkg.sv
package pbu_pkg;

   typedef enum logic [1:0] {
      BK_COND = 2'd0,
      BK_CALL = 2'd1,
      BK_RET  = 2'd2,
      BK_NOP  = 2'd3
   } br_kind_e;

   localparam int DEF_FSZ_W   = 7;
   localparam int DEF_LOC_W   = 7;
   localparam int DEF_ROT_W   = 4;
   localparam int DEF_BGR_W   = 7;
   localparam int DEF_BFR_W   = 7;
   localparam int DEF_BPR_W   = 6;
   localparam int DEF_EC_W    = 6;
   localparam int DEF_PL_W    = 2;
   localparam int DEF_ADDR_W  = 64;
   localparam int DEF_LSEL_W  = 3;
   localparam int DEF_STEP    = 16;

endpackage

// File: rtl/pbu_frame_calc.sv
module pbu_frame_calc #(
   parameter int FSZ_W    = pbu_pkg::DEF_FSZ_W,
   parameter int LOC_W    = pbu_pkg::DEF_LOC_W,
   parameter int ROT_W    = pbu_pkg::DEF_ROT_W,
   parameter int BGR_W    = pbu_pkg::DEF_BGR_W,
   parameter int BFR_W    = pbu_pkg::DEF_BFR_W,
   parameter int BPR_W    = pbu_pkg::DEF_BPR_W,
   parameter bit SATURATE = 1'b1,
   localparam int LOC_LO  = FSZ_W,
   localparam int ROT_LO  = LOC_LO + LOC_W,
   localparam int BGR_LO  = ROT_LO + ROT_W,
   localparam int BFR_LO  = BGR_LO + BGR_W,
   localparam int BPR_LO  = BFR_LO + BFR_W,
   localparam int FRM_W   = BPR_LO + BPR_W
) (
   input  logic [FRM_W-1:0] cur_frame,
   output logic [FRM_W-1:0] callee_frame
);

   if (LOC_W > FSZ_W) begin : g_bad_loc
      $error("pbu_frame_calc: locals field wider than size field");
   end
   if (FSZ_W < 1 || ROT_W < 1) begin : g_bad_w
      $error("pbu_frame_calc: field widths must be positive");
   end

   logic [FSZ_W-1:0] old_size;
   logic [FSZ_W-1:0] old_loc;
   logic [FSZ_W-1:0] out_size;
   logic             loc_over;

   assign old_size = cur_frame[FSZ_W-1:0];
   assign old_loc  = FSZ_W'(cur_frame[LOC_LO +: LOC_W]);
   assign loc_over = old_loc > old_size;

   if (SATURATE) begin : g_sat
      assign out_size = loc_over ? '0 : (old_size - old_loc);
   end else begin : g_wrap
      assign out_size = old_size - old_loc;
   end

   always_comb begin
      callee_frame                   = '0;
      callee_frame[FSZ_W-1:0]        = out_size;
      callee_frame[LOC_LO +: LOC_W]  = '0;
      callee_frame[ROT_LO +: ROT_W]  = '0;
      callee_frame[BGR_LO +: BGR_W]  = '0;
      callee_frame[BFR_LO +: BFR_W]  = '0;
      callee_frame[BPR_LO +: BPR_W]  = '0;
   end

endmodule

// File: rtl/pbu_priv_resolve.sv
module pbu_priv_resolve #(
   parameter int PL_W = pbu_pkg::DEF_PL_W
) (
   input  logic [PL_W-1:0] cur_pl,
   input  logic [PL_W-1:0] saved_pl,
   input  logic            trap_en,
   output logic [PL_W-1:0] ret_pl,
   output logic            ret_trap
);

   if (PL_W < 1) begin : g_bad_pl
      $error("pbu_priv_resolve: privilege width must be positive");
   end

   logic drops;

   assign drops    = saved_pl > cur_pl;
   assign ret_pl   = drops ? saved_pl : cur_pl;
   assign ret_trap = drops & trap_en;

endmodule

// File: rtl/pbu_link_gen.sv
module pbu_link_gen #(
   parameter int ADDR_W = pbu_pkg::DEF_ADDR_W,
   parameter int STEP   = pbu_pkg::DEF_STEP,
   localparam int SH    = $clog2(STEP),
   localparam bit POW2  = (STEP > 0) && ((STEP & (STEP - 1)) == 0)
) (
   input  logic [ADDR_W-1:0] bundle_addr,
   output logic [ADDR_W-1:0] link_addr
);

   if (STEP < 1) begin : g_bad_step
      $error("pbu_link_gen: step must be positive");
   end
   if (SH >= ADDR_W) begin : g_bad_sh
      $error("pbu_link_gen: step does not fit the address width");
   end

   if (POW2 && SH > 0) begin : g_split
      logic [ADDR_W-SH-1:0] upper_inc;
      assign upper_inc = bundle_addr[ADDR_W-1:SH] + 1'b1;
      assign link_addr = {upper_inc, bundle_addr[SH-1:0]};
   end else begin : g_full
      assign link_addr = bundle_addr + ADDR_W'(STEP);
   end

endmodule

// File: rtl/pred_branch_unit.sv
module pred_branch_unit #(
   parameter int FSZ_W     = pbu_pkg::DEF_FSZ_W,
   parameter int LOC_W     = pbu_pkg::DEF_LOC_W,
   parameter int ROT_W     = pbu_pkg::DEF_ROT_W,
   parameter int BGR_W     = pbu_pkg::DEF_BGR_W,
   parameter int BFR_W     = pbu_pkg::DEF_BFR_W,
   parameter int BPR_W     = pbu_pkg::DEF_BPR_W,
   parameter int EC_W      = pbu_pkg::DEF_EC_W,
   parameter int PL_W      = pbu_pkg::DEF_PL_W,
   parameter int ADDR_W    = pbu_pkg::DEF_ADDR_W,
   parameter int LSEL_W    = pbu_pkg::DEF_LSEL_W,
   parameter int LINK_STEP = pbu_pkg::DEF_STEP,
   parameter bit SATURATE  = 1'b1,
   localparam int FRM_W    = FSZ_W + LOC_W + ROT_W + BGR_W + BFR_W + BPR_W,
   localparam int SAV_W    = PL_W + EC_W + FRM_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        in_kind,
   input  logic              in_pred,
   input  logic [LSEL_W-1:0] in_link_sel,
   input  logic [FRM_W-1:0]  in_frame,
   input  logic [EC_W-1:0]   in_ec,
   input  logic [PL_W-1:0]   in_priv,
   input  logic [SAV_W-1:0]  in_saved,
   input  logic              in_lp_trap_en,
   input  logic [ADDR_W-1:0] in_bundle_addr,
   output logic              out_valid,
   output logic              out_taken,
   output logic [FRM_W-1:0]  out_frame,
   output logic [EC_W-1:0]   out_ec,
   output logic [PL_W-1:0]   out_priv,
   output logic [SAV_W-1:0]  out_saved,
   output logic              out_link_we,
   output logic [LSEL_W-1:0] out_link_sel,
   output logic [ADDR_W-1:0] out_link_data,
   output logic              out_trap
);

   import pbu_pkg::*;

   localparam int SV_EC_LO = FRM_W;
   localparam int SV_PL_LO = FRM_W + EC_W;

   if (EC_W < 1 || LSEL_W < 1) begin : g_bad_top
      $error("pred_branch_unit: epilog and selector widths must be positive");
   end

   // kind decode
   logic is_cond, is_call, is_ret, taken;
   assign is_cond = in_kind == BK_COND;
   assign is_call = in_kind == BK_CALL;
   assign is_ret  = in_kind == BK_RET;
   assign taken   = in_pred & (is_cond | is_call | is_ret);

   // helper datapaths
   logic [FRM_W-1:0]  callee_frame;
   logic [PL_W-1:0]   ret_pl;
   logic              ret_trap;
   logic [ADDR_W-1:0] link_addr;

   pbu_frame_calc #(
      .FSZ_W(FSZ_W), .LOC_W(LOC_W), .ROT_W(ROT_W),
      .BGR_W(BGR_W), .BFR_W(BFR_W), .BPR_W(BPR_W),
      .SATURATE(SATURATE)
   ) u_frame (
      .cur_frame    (in_frame),
      .callee_frame (callee_frame)
   );

   pbu_priv_resolve #(.PL_W(PL_W)) u_priv (
      .cur_pl   (in_priv),
      .saved_pl (in_saved[SV_PL_LO +: PL_W]),
      .trap_en  (in_lp_trap_en),
      .ret_pl   (ret_pl),
      .ret_trap (ret_trap)
   );

   pbu_link_gen #(.ADDR_W(ADDR_W), .STEP(LINK_STEP)) u_link (
      .bundle_addr (in_bundle_addr),
      .link_addr   (link_addr)
   );

   // next state selection
   logic [FRM_W-1:0] nxt_frame;
   logic [EC_W-1:0]  nxt_ec;
   logic [PL_W-1:0]  nxt_priv;
   logic [SAV_W-1:0] nxt_saved;
   logic             nxt_we;
   logic             nxt_trap;

   always_comb begin
      nxt_frame = in_frame;
      nxt_ec    = in_ec;
      nxt_priv  = in_priv;
      nxt_saved = in_saved;
      nxt_we    = 1'b0;
      nxt_trap  = 1'b0;
      if (taken && is_call) begin
         nxt_saved = {in_priv, in_ec, in_frame};
         nxt_frame = callee_frame;
         nxt_we    = 1'b1;
      end else if (taken && is_ret) begin
         nxt_frame = in_saved[FRM_W-1:0];
         nxt_ec    = in_saved[SV_EC_LO +: EC_W];
         nxt_priv  = ret_pl;
         nxt_trap  = ret_trap;
      end
   end

   // result register
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid     <= 1'b0;
         out_taken     <= 1'b0;
         out_frame     <= '0;
         out_ec        <= '0;
         out_priv      <= '0;
         out_saved     <= '0;
         out_link_we   <= 1'b0;
         out_link_sel  <= '0;
         out_link_data <= '0;
         out_trap      <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_taken     <= taken;
            out_frame     <= nxt_frame;
            out_ec        <= nxt_ec;
            out_priv      <= nxt_priv;
            out_saved     <= nxt_saved;
            out_link_we   <= nxt_we;
            out_link_sel  <= in_link_sel;
            out_link_data <= link_addr;
            out_trap      <= nxt_trap;
         end else begin
            out_link_we   <= 1'b0;
            out_trap      <= 1'b0;
            out_taken     <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/pbu_checker.sv
module pbu_checker #(
   parameter int FRM_W  = 38,
   parameter int EC_W   = 6,
   parameter int PL_W   = 2,
   parameter int ADDR_W = 64,
   parameter int STEP   = 16,
   parameter int RB_LO  = 18,
   localparam int SAV_W = PL_W + EC_W + FRM_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [1:0]        in_kind,
   input logic              in_pred,
   input logic [FRM_W-1:0]  in_frame,
   input logic [EC_W-1:0]   in_ec,
   input logic [PL_W-1:0]   in_priv,
   input logic [SAV_W-1:0]  in_saved,
   input logic [ADDR_W-1:0] in_bundle_addr,
   input logic              out_valid,
   input logic              out_taken,
   input logic [FRM_W-1:0]  out_frame,
   input logic [PL_W-1:0]   out_priv,
   input logic [SAV_W-1:0]  out_saved,
   input logic              out_link_we,
   input logic [ADDR_W-1:0] out_link_data,
   input logic              out_trap
);

   localparam int SV_PL_LO = FRM_W + EC_W;

   assert_result_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   assert_nop_untaken_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_kind == pbu_pkg::BK_NOP) |=> !out_taken);

   assert_untaken_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_pred) |=> (!out_taken && !out_link_we && !out_trap
         && out_frame == $past(in_frame) && out_priv == $past(in_priv)));

   assert_call_packs_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_pred && in_kind == pbu_pkg::BK_CALL)
      |=> out_saved == {$past(in_priv), $past(in_ec), $past(in_frame)});

   assert_call_bases_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_pred && in_kind == pbu_pkg::BK_CALL)
      |=> out_frame[FRM_W-1:RB_LO] == '0);

   assert_link_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_link_we |-> (out_valid && out_taken
         && out_link_data == $past(in_bundle_addr) + ADDR_W'(STEP)));

   assert_no_raise_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_pred && in_kind == pbu_pkg::BK_RET)
      |=> (out_priv >= $past(in_priv)
           && out_priv >= $past(in_saved[SV_PL_LO +: PL_W])));

   assert_trap_on_return_R11: assert property (@(posedge clk) disable iff (!rst_n)
      out_trap |-> (out_valid && out_taken && !out_link_we));

endmodule

bind pred_branch_unit pbu_checker #(
   .FRM_W  (FSZ_W + LOC_W + ROT_W + BGR_W + BFR_W + BPR_W),
   .EC_W   (EC_W),
   .PL_W   (PL_W),
   .ADDR_W (ADDR_W),
   .STEP   (LINK_STEP),
   .RB_LO  (FSZ_W + LOC_W + ROT_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .in_valid       (in_valid),
   .in_kind        (in_kind),
   .in_pred        (in_pred),
   .in_frame       (in_frame),
   .in_ec          (in_ec),
   .in_priv        (in_priv),
   .in_saved       (in_saved),
   .in_bundle_addr (in_bundle_addr),
   .out_valid      (out_valid),
   .out_taken      (out_taken),
   .out_frame      (out_frame),
   .out_priv       (out_priv),
   .out_saved      (out_saved),
   .out_link_we    (out_link_we),
   .out_link_data  (out_link_data),
   .out_trap       (out_trap)
);

// File: tb/sim_pred_branch_unit.sv
`timescale 1ns/1ps
module sim_pred_branch_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  in_kind = '0;
   logic        in_pred = 1'b0;
   logic [2:0]  in_link_sel = '0;
   logic [37:0] in_frame = '0;
   logic [5:0]  in_ec = '0;
   logic [1:0]  in_priv = '0;
   logic [45:0] in_saved = '0;
   logic        in_lp_trap_en = 1'b0;
   logic [63:0] in_bundle_addr = '0;
   logic        out_valid, out_taken, out_link_we, out_trap;
   logic [37:0] out_frame;
   logic [5:0]  out_ec;
   logic [1:0]  out_priv;
   logic [45:0] out_saved;
   logic [2:0]  out_link_sel;
   logic [63:0] out_link_data;

   always #2.5 clk = ~clk;

   pred_branch_unit u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
      .in_pred(in_pred), .in_link_sel(in_link_sel), .in_frame(in_frame),
      .in_ec(in_ec), .in_priv(in_priv), .in_saved(in_saved),
      .in_lp_trap_en(in_lp_trap_en), .in_bundle_addr(in_bundle_addr),
      .out_valid(out_valid), .out_taken(out_taken), .out_frame(out_frame),
      .out_ec(out_ec), .out_priv(out_priv), .out_saved(out_saved),
      .out_link_we(out_link_we), .out_link_sel(out_link_sel),
      .out_link_data(out_link_data), .out_trap(out_trap)
   );

   typedef struct {
      logic        taken;
      logic [37:0] frame;
      logic [5:0]  ec;
      logic [1:0]  priv;
      logic [45:0] saved;
      logic        we;
      logic [2:0]  sel;
      logic [63:0] data;
      logic        trap;
      int          cyc;
      string       tag;
   } exp_t;

   exp_t sb[$];
   int   n_tests = 0;
   int   n_fail  = 0;
   int   cyc     = 0;
   bit   done    = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [37:0] mk_frame(int sz, int loc, int rot, int bg, int bf, int bp);
      return {6'(bp), 7'(bf), 7'(bg), 4'(rot), 7'(loc), 7'(sz)};
   endfunction

   task automatic issue(input logic [1:0] kind, input logic pred, input logic [2:0] sel,
                        input logic [37:0] frm, input logic [5:0] ec, input logic [1:0] pl,
                        input logic [45:0] sv, input logic en, input logic [63:0] addr,
                        input string tag);
      exp_t e;
      logic [6:0] sz, loc;
      logic [1:0] spl;
      @(negedge clk);
      in_valid = 1'b1; in_kind = kind; in_pred = pred; in_link_sel = sel;
      in_frame = frm; in_ec = ec; in_priv = pl; in_saved = sv;
      in_lp_trap_en = en; in_bundle_addr = addr;
      e.taken = pred && (kind != 2'd3);
      e.frame = frm; e.ec = ec; e.priv = pl; e.saved = sv;
      e.we = 1'b0; e.sel = sel; e.data = addr + 64'd16; e.trap = 1'b0;
      e.cyc = cyc + 1; e.tag = tag;
      if (e.taken && kind == 2'd1) begin
         e.saved = {pl, ec, frm};
         sz  = frm[6:0];
         loc = frm[13:7];
         e.frame = {31'd0, (loc > sz) ? 7'd0 : 7'(sz - loc)};
         e.we = 1'b1;
      end else if (e.taken && kind == 2'd2) begin
         e.frame = sv[37:0];
         e.ec    = sv[43:38];
         spl     = sv[45:44];
         e.priv  = (spl > pl) ? spl : pl;
         e.trap  = en && (spl > pl);
      end
      sb.push_back(e);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n && out_valid && !done) begin
         n_tests++;
         if (sb.size() == 0) begin
            n_fail++;
            $display("FAIL R1: unexpected result strobe, actual out_valid=1 expected 0");
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (cyc != e.cyc) begin
               n_fail++;
               $display("FAIL R1 (%s): result cycle actual %0d expected %0d", e.tag, cyc, e.cyc);
            end else if (out_taken !== e.taken || out_frame !== e.frame || out_ec !== e.ec ||
                         out_priv !== e.priv || out_saved !== e.saved ||
                         out_link_we !== e.we || out_trap !== e.trap ||
                         (e.we && (out_link_sel !== e.sel || out_link_data !== e.data))) begin
               n_fail++;
               $display("FAIL %s: actual tk=%0b frm=%h ec=%h pl=%0d sv=%h we=%0b sel=%0d ld=%h trap=%0b expected tk=%0b frm=%h ec=%h pl=%0d sv=%h we=%0b sel=%0d ld=%h trap=%0b",
                        e.tag, out_taken, out_frame, out_ec, out_priv, out_saved, out_link_we,
                        out_link_sel, out_link_data, out_trap, e.taken, e.frame, e.ec, e.priv,
                        e.saved, e.we, e.sel, e.data, e.trap);
            end
         end
      end
   end

   // watchdog
   initial begin
      for (int i = 0; i < 20000; i++) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [37:0] f;
      logic [45:0] s;
      repeat (3) @(negedge clk);
      n_tests++;
      if (out_valid !== 1'b0 || out_link_we !== 1'b0 || out_trap !== 1'b0) begin
         n_fail++;
         $display("FAIL R1 reset: actual v=%0b we=%0b trap=%0b expected 0 0 0",
                  out_valid, out_link_we, out_trap);
      end
      @(negedge clk);
      rst_n = 1'b1;

      f = mk_frame(40, 12, 3, 5, 9, 17);
      s = {2'd3, 6'd9, mk_frame(20, 4, 1, 2, 3, 4)};
      issue(2'd0, 1'b0, 3'd1, f, 6'd5, 2'd1, s, 1'b1, 64'h1000, "R3 cond pred0");
      issue(2'd0, 1'b1, 3'd1, f, 6'd5, 2'd1, s, 1'b1, 64'h1000, "R4 cond taken");
      issue(2'd1, 1'b1, 3'd2, f, 6'd5, 2'd1, s, 1'b0, 64'h2000, "R5 R6 R7 R8 call taken");
      issue(2'd1, 1'b0, 3'd2, f, 6'd5, 2'd1, s, 1'b0, 64'h2000, "R3 call pred0");
      issue(2'd1, 1'b1, 3'd7, mk_frame(10, 30, 2, 1, 1, 1), 6'd0, 2'd0, s, 1'b0,
            64'hFFFF_FFFF_FFFF_FFF0, "R6 R8 call locals over size");
      issue(2'd1, 1'b1, 3'd4, mk_frame(25, 25, 0, 0, 0, 0), 6'd63, 2'd3, s, 1'b0,
            64'h0000_0000_0000_0FF0, "R6 R8 call equal locals");
      issue(2'd2, 1'b1, 3'd0, f, 6'd5, 2'd1, s, 1'b1, 64'h3000, "R9 R10 R11 return drop trap");
      issue(2'd2, 1'b1, 3'd0, f, 6'd5, 2'd1, s, 1'b0, 64'h3000, "R11 return drop no enable");
      issue(2'd2, 1'b1, 3'd0, f, 6'd5, 2'd3, {2'd0, s[43:0]}, 1'b1, 64'h3000, "R10 return no raise");
      issue(2'd2, 1'b1, 3'd0, f, 6'd5, 2'd2, {2'd2, s[43:0]}, 1'b1, 64'h3000, "R10 R11 return equal level");
      issue(2'd2, 1'b0, 3'd0, f, 6'd5, 2'd0, s, 1'b1, 64'h3000, "R3 return pred0");
      issue(2'd3, 1'b1, 3'd3, f, 6'd5, 2'd0, s, 1'b1, 64'h3000, "R2 nop kind");
      idle(3);
      issue(2'd2, 1'b1, 3'd0, f, 6'd7, 2'd0, s, 1'b1, 64'h4000, "R1 R9 after gap");
      idle(1);
      for (int i = 0; i < 40; i++) begin
         logic [1:0] k;
         k = 2'($urandom_range(0, 3));
         issue(k, 1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)),
               {$urandom, $urandom}, 6'($urandom), 2'($urandom), {$urandom, $urandom},
               1'($urandom_range(0, 1)), {$urandom, $urandom}, "R2 R3 R5 R9 R10 R11 mixed");
      end
      idle(4);
      n_tests++;
      if (sb.size() != 0) begin
         n_fail++;
         $display("FAIL R1: missing results, actual pending %0d expected 0", sb.size());
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule